// File: doc/BRIEF.md
# Eight-Channel Configurable Match Timer Group

This block holds eight match channels, numbered 4 to 11, for a system timer. Each channel owns a 32-bit up-counter, a 32-bit match value and a control word. The control word picks the tick source from eight tick-enable inputs. It also says whether the channel watches its own counter or the counter of its group leader. The leaders are channel 4 for channels 4 to 7, channel 8 for channels 8 and 9, and channel 10 for channels 10 and 11. Further control bits set clear-on-match, periodic re-arming, borrowing the tick of the even neighbour (channels 9 and 11 only), and capture of the even neighbour's counter when the odd counter is read.

A match event occurs on the tick that moves the watched counter from match-1 to the match value. An event sets a sticky status bit if that channel is enabled. One combined interrupt is high while any status bit is set. Software reaches every register through a plain word-addressed read/write strobe port. Reads return data one cycle after the strobe. There is no stream data path, so the port has no back-pressure: a strobe is always taken in the cycle it is presented.

Top module: `match_group`

## Requirements
- R1: After reset every counter, match value, control word, the status word, the enable word and the snapshot read as zero, and `irq` is low.
- R2: Control bits 2:0 select the tick source: code k in 1..7 advances the counter by one in each cycle where `tick_in[k]` is high, and code 0 never advances it. A counter only advances while the channel watches its own counter.
- R3: A channel watches its own counter when it is a group leader (4, 8, 10) or its control bit 7 is set. Otherwise it watches its leader's counter, and its own counter holds its value.
- R4: When the watched counter advances from match-1 to the match value, a channel that is armed and enabled sets its status bit (bit n of the status word for channel n) at that clock edge, and `irq` goes high.
- R5: A match on a channel whose enable bit is clear (bit n of the enable word, bits 11:4) leaves its status bit clear.
- R6: With control bit 3 set, a channel watching its own counter loads zero instead of the match value on the matching tick.
- R7: Without control bit 6 a channel is one-shot: after one event it stays disarmed until its match value or control word is written. With bit 6 set it re-arms after every event.
- R8: Channels 4 to 7 keep control bits 7:0 and channels 8 to 11 keep bits 9:0. Bits beyond those read as zero.
- R9: On channel 9 or 11, control bit 8 makes the channel use the tick selected by its even neighbour (8 or 10) in place of its own selection.
- R10: Reading the counter of channel 9 or 11 while its control bit 9 is set copies the even neighbour's counter into the snapshot register. The snapshot holds its value until the next such read.
- R11: Writing the status word clears each status bit written as one and leaves the others unchanged. `irq` is low only when status bits 11:4 are all clear.
- R12: Word addresses are: counter of channel n at n-4, match value at n+4, control word at n+12, status 24, enable 25, snapshot 26. Read data appears on `bus_rdata` one cycle after `bus_rd`. A counter write takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 8 | Tick enables; index = source code, index 0 unused |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Combined match interrupt |

## Verification
A tick presented during a cycle changes a counter at the next rising edge. A match seen on that same tick sets its status bit and `irq` at that same edge. Register writes land at the edge that ends their strobe cycle. Read data and any snapshot capture are due one edge after the read strobe. The bench drives every stimulus on the falling edge and samples on the following falling edge, so each expected value is read half a cycle after the edge that produces it.

// File: rtl/match_group_pkg.sv
package match_group_pkg;
  localparam int NCH      = 8;
  localparam int NSRC     = 8;
  localparam int SELW     = $clog2(NSRC);
  localparam int IDX_W    = $clog2(NCH);
  localparam int CTRL_LO_W = 8;
  localparam int CTRL_HI_W = 10;
  localparam int STAT_LSB = 4;

  localparam int BK_CNT   = 0;
  localparam int BK_MATCH = 1;
  localparam int BK_CTRL  = 2;
  localparam int BK_MISC  = 3;
  localparam int MISC_STATUS = 0;
  localparam int MISC_ENABLE = 1;
  localparam int MISC_SNAP   = 2;

  localparam int B_CLR_ON_MATCH = 3;
  localparam int B_PERIODIC     = 6;
  localparam int B_OWN_CNT      = 7;
  localparam int B_BORROW_TICK  = 8;
  localparam int B_CAPTURE      = 9;

  function automatic int leader_of(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction

  function automatic bit is_pair_odd(input int idx);
    return (idx == 5) || (idx == 7);
  endfunction
endpackage

// File: rtl/match_group_tick_sel.sv
module match_group_tick_sel #(
  parameter int NSRC = 8,
  parameter int SELW = 3
) (
  input  logic [NSRC-1:0] tick_in,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  always_comb begin
    tick = 1'b0;
    if (sel != '0) tick = tick_in[sel];
  end
endmodule

// File: rtl/match_group_channel.sv
module match_group_channel #(
  parameter int DW  = 32,
  parameter int CW  = 8,
  parameter int CHW = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_wr,
  input  logic           match_wr,
  input  logic           ctrl_wr,
  input  logic [DW-1:0]  wdata,
  input  logic           self_watch,
  input  logic           own_adv,
  input  logic [DW-1:0]  watch_val,
  input  logic           watch_adv,
  output logic [DW-1:0]  cnt_q,
  output logic [DW-1:0]  match_q,
  output logic [CHW-1:0] ctrl_q,
  output logic           event_o
);
  import match_group_pkg::*;

  logic [CW-1:0] ctrl_r;
  logic          armed;

  assign ctrl_q  = CHW'(ctrl_r);
  assign event_o = armed && watch_adv && ((watch_val + DW'(1)) == match_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_r <= '0;
    end else if (ctrl_wr) begin
      ctrl_r <= wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
    end else if (match_wr) begin
      match_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (match_wr || ctrl_wr) begin
      armed <= 1'b1;
    end else if (event_o && !ctrl_r[B_PERIODIC]) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr) begin
      cnt_q <= wdata;
    end else if (own_adv) begin
      if (event_o && self_watch && ctrl_r[B_CLR_ON_MATCH])
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + DW'(1);
    end
  end
endmodule

// File: rtl/match_group_regs.sv
module match_group_regs #(
  parameter int DW  = 32,
  parameter int AW  = 5,
  parameter int NCH = 8,
  parameter int CHW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [AW-1:0]             bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic [NCH-1:0][DW-1:0]    ch_cnt,
  input  logic [NCH-1:0][DW-1:0]    ch_match,
  input  logic [NCH-1:0][CHW-1:0]   ch_ctrl,
  input  logic [NCH-1:0]            ch_event,
  output logic [NCH-1:0]            cnt_wr,
  output logic [NCH-1:0]            match_wr,
  output logic [NCH-1:0]            ctrl_wr,
  output logic [NCH-1:0]            status_q,
  output logic [NCH-1:0]            enable_q,
  output logic [DW-1:0]             snap_q,
  output logic                      cap_rd,
  output logic [DW-1:0]             bus_rdata,
  output logic                      irq
);
  import match_group_pkg::*;

  localparam int BKW = AW - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [BKW-1:0]   bank;
  logic [NCH-1:0]   sel_oh;
  logic             st_wr, en_wr;
  logic [DW-1:0]    cap_val;
  logic [DW-1:0]    rd_next;

  assign idx    = bus_addr[IDX_W-1:0];
  assign bank   = bus_addr[AW-1:IDX_W];
  assign sel_oh = NCH'(1) << idx;

  assign cnt_wr   = (bus_wr && bank == BKW'(BK_CNT))   ? sel_oh : '0;
  assign match_wr = (bus_wr && bank == BKW'(BK_MATCH)) ? sel_oh : '0;
  assign ctrl_wr  = (bus_wr && bank == BKW'(BK_CTRL))  ? sel_oh : '0;
  assign st_wr    = bus_wr && bank == BKW'(BK_MISC) && idx == IDX_W'(MISC_STATUS);
  assign en_wr    = bus_wr && bank == BKW'(BK_MISC) && idx == IDX_W'(MISC_ENABLE);

  always_comb begin
    cap_rd  = 1'b0;
    cap_val = '0;
    for (int i = 1; i < NCH; i++) begin
      if (is_pair_odd(i) && bus_rd && bank == BKW'(BK_CNT) &&
          idx == IDX_W'(i) && ch_ctrl[i][B_CAPTURE]) begin
        cap_rd  = 1'b1;
        cap_val = ch_cnt[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= '0;
    else if (cap_rd) snap_q <= cap_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) enable_q <= '0;
    else if (en_wr) enable_q <= bus_wdata[STAT_LSB +: NCH];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= (status_q & ~(st_wr ? bus_wdata[STAT_LSB +: NCH] : '0))
                | (ch_event & enable_q);
    end
  end

  assign irq = |status_q;

  always_comb begin
    rd_next = '0;
    case (bank)
      BKW'(BK_CNT):   rd_next = ch_cnt[idx];
      BKW'(BK_MATCH): rd_next = ch_match[idx];
      BKW'(BK_CTRL):  rd_next = DW'(ch_ctrl[idx]);
      default: begin
        if (idx == IDX_W'(MISC_STATUS))      rd_next[STAT_LSB +: NCH] = status_q;
        else if (idx == IDX_W'(MISC_ENABLE)) rd_next[STAT_LSB +: NCH] = enable_q;
        else if (idx == IDX_W'(MISC_SNAP))   rd_next = snap_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/match_group.sv
module match_group #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    tick_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  import match_group_pkg::*;

  localparam int CHW = CTRL_HI_W;

  logic [NCH-1:0][DW-1:0]  ch_cnt;
  logic [NCH-1:0][DW-1:0]  ch_match;
  logic [NCH-1:0][CHW-1:0] ch_ctrl;
  logic [NCH-1:0]          ch_event;
  logic [NCH-1:0]          cnt_wr, match_wr, ctrl_wr;
  logic [NCH-1:0]          src_tick, eff_tick, self_watch, adv;
  logic [NCH-1:0]          status_q, enable_q;
  logic [DW-1:0]           snap_q;
  logic                    cap_rd;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int LD = leader_of(i);
    localparam int CW = (i < 4) ? CTRL_LO_W : CTRL_HI_W;

    logic [DW-1:0] watch_val;
    logic          watch_adv;

    match_group_tick_sel #(.NSRC(NSRC), .SELW(SELW)) u_sel (
      .tick_in (tick_in),
      .sel     (ch_ctrl[i][SELW-1:0]),
      .tick    (src_tick[i])
    );

    if (is_pair_odd(i)) begin : g_borrow
      assign eff_tick[i] = ch_ctrl[i][B_BORROW_TICK] ? src_tick[i-1] : src_tick[i];
    end else begin : g_plain
      assign eff_tick[i] = src_tick[i];
    end

    if (LD == i) begin : g_leader
      assign self_watch[i] = 1'b1;
    end else begin : g_member
      assign self_watch[i] = ch_ctrl[i][B_OWN_CNT];
    end

    assign adv[i]    = self_watch[i] && eff_tick[i] && !cnt_wr[i];
    assign watch_val = self_watch[i] ? ch_cnt[i] : ch_cnt[LD];
    assign watch_adv = self_watch[i] ? adv[i]    : adv[LD];

    match_group_channel #(.DW(DW), .CW(CW), .CHW(CHW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_wr     (cnt_wr[i]),
      .match_wr   (match_wr[i]),
      .ctrl_wr    (ctrl_wr[i]),
      .wdata      (bus_wdata),
      .self_watch (self_watch[i]),
      .own_adv    (adv[i]),
      .watch_val  (watch_val),
      .watch_adv  (watch_adv),
      .cnt_q      (ch_cnt[i]),
      .match_q    (ch_match[i]),
      .ctrl_q     (ch_ctrl[i]),
      .event_o    (ch_event[i])
    );
  end

  match_group_regs #(.DW(DW), .AW(AW), .NCH(NCH), .CHW(CHW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ch_cnt    (ch_cnt),
    .ch_match  (ch_match),
    .ch_ctrl   (ch_ctrl),
    .ch_event  (ch_event),
    .cnt_wr    (cnt_wr),
    .match_wr  (match_wr),
    .ctrl_wr   (ctrl_wr),
    .status_q  (status_q),
    .enable_q  (enable_q),
    .snap_q    (snap_q),
    .cap_rd    (cap_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );
endmodule

// File: rtl/match_group_chk.sv
module match_group_chk #(
  parameter int DW  = 32,
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   irq,
  input logic [NCH-1:0]         status_q,
  input logic [NCH-1:0]         enable_q,
  input logic [NCH-1:0]         ch_event,
  input logic [NCH-1:0][DW-1:0] ch_cnt,
  input logic [NCH-1:0]         cnt_wr,
  input logic [DW-1:0]          snap_q,
  input logic                   cap_rd
);
  logic seen_edge;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_step
    // R2 and R6: a counter moves by one, clears to zero, or takes a bus write
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_edge && ch_cnt[i] != $past(ch_cnt[i])) |->
        ($past(cnt_wr[i]) || ch_cnt[i] == $past(ch_cnt[i]) + DW'(1) || ch_cnt[i] == '0));
  end

  // R4: the interrupt rises only after an enabled match event
  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $rose(irq)) |-> $past(|(ch_event & enable_q)));

  // R5: a status bit never rises on a disabled channel
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

  // R10: the snapshot changes only after a capturing read
  p_snapshot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && !$stable(snap_q)) |-> $past(cap_rd));
endmodule

bind match_group match_group_chk #(.DW(DW), .NCH(match_group_pkg::NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .status_q (status_q),
  .enable_q (enable_q),
  .ch_event (ch_event),
  .ch_cnt   (ch_cnt),
  .cnt_wr   (cnt_wr),
  .snap_q   (snap_q),
  .cap_rd   (cap_rd)
);

// File: tb/match_group_test.sv
module match_group_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam int A_STATUS = 24;
  localparam int A_ENABLE = 25;
  localparam int A_SNAP   = 26;

  always #10 clk = ~clk;

  match_group uut (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic int a_cnt(input int ch);   return ch - 4;  endfunction
  function automatic int a_match(input int ch); return ch + 4;  endfunction
  function automatic int a_ctrl(input int ch);  return ch + 12; endfunction
  function automatic logic [31:0] stat_bit(input int ch); return 32'(1) << ch; endfunction
  function automatic logic [31:0] ctrl_keep(input int ch, input logic [31:0] v);
    return (ch < 8) ? (v & 32'hFF) : (v & 32'h3FF);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input logic [7:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick_in = m;
      @(negedge clk);
    end
    tick_in = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(A_STATUS, v); check("R1 status", v, 0);
    rd(A_ENABLE, v); check("R1 enable", v, 0);
    rd(A_SNAP, v);   check("R1 snapshot", v, 0);
    rd(a_cnt(4), v); check("R1 counter4", v, 0);
    rd(a_match(11), v); check("R1 match11", v, 0);
    rd(a_ctrl(8), v); check("R1 ctrl8", v, 0);

    // R8 control width per channel, random values
    for (int ch = 4; ch < 12; ch++) begin
      logic [31:0] r;
      r = $urandom;
      wr(a_ctrl(ch), r);
      rd(a_ctrl(ch), v);
      check("R8 ctrl mask", v, ctrl_keep(ch, r));
    end
    for (int ch = 4; ch < 12; ch++) wr(a_ctrl(ch), 0);

    // R2 random tick patterns on leader channel 4
    for (int t = 0; t < 6; t++) begin
      int code, n;
      code = 1 + ($urandom % 7);
      n = 0;
      wr(a_ctrl(4), 32'(code));
      wr(a_cnt(4), 0);
      for (int k = 0; k < 16 + ($urandom % 24); k++) begin
        logic [7:0] m;
        m = 8'($urandom);
        if (m[code]) n++;
        ticks(m, 1);
      end
      rd(a_cnt(4), v); check("R2 random count", v, 32'(n));
    end
    wr(a_ctrl(4), 0);
    wr(a_cnt(4), 0);
    ticks(8'hFF, 10);
    rd(a_cnt(4), v); check("R2 code 0 stops", v, 0);

    // R3/R4 shared counter: channel 5 follows channel 4
    wr(a_ctrl(4), 1);
    wr(a_ctrl(5), 2);
    wr(a_match(5), 5);
    wr(A_ENABLE, stat_bit(5));
    ticks(8'h06, 5);
    rd(a_cnt(4), v); check("R3 leader counts", v, 5);
    rd(a_cnt(5), v); check("R3 member counter holds", v, 0);
    rd(A_STATUS, v); check("R4 status on match", v, stat_bit(5));
    check("R4 irq high", 32'(irq), 1);

    // R11 write-one-to-clear
    wr(A_STATUS, 0);
    rd(A_STATUS, v); check("R11 zero write keeps", v, stat_bit(5));
    wr(A_STATUS, 32'hFFFF_FFFF);
    rd(A_STATUS, v); check("R11 cleared", v, 0);
    check("R11 irq low", 32'(irq), 0);

    // R5 disabled channel 6, then enabled
    wr(a_match(6), 8);
    ticks(8'h02, 3);
    rd(A_STATUS, v); check("R5 disabled no status", v, 0);
    check("R5 irq low", 32'(irq), 0);
    wr(A_ENABLE, stat_bit(5) | stat_bit(6));
    wr(a_match(6), 10);
    ticks(8'h02, 2);
    rd(A_STATUS, v); check("R4 enabled ch6", v, stat_bit(6));
    wr(A_STATUS, 32'hFFFF_FFFF);

    // R6/R7 clear-on-match, one-shot and periodic on channel 10
    wr(a_ctrl(10), 32'h0C);
    wr(a_cnt(10), 0);
    wr(a_match(10), 3);
    wr(A_ENABLE, stat_bit(10));
    ticks(8'h10, 3);
    rd(A_STATUS, v); check("R4 ch10 match", v, stat_bit(10));
    rd(a_cnt(10), v); check("R6 cleared on match", v, 0);
    wr(A_STATUS, stat_bit(10));
    ticks(8'h10, 3);
    rd(A_STATUS, v); check("R7 one-shot silent", v, 0);
    rd(a_cnt(10), v); check("R7 one-shot no clear", v, 3);
    wr(a_ctrl(10), 32'h4C);
    wr(a_cnt(10), 0);
    ticks(8'h10, 3);
    rd(A_STATUS, v); check("R7 periodic first", v, stat_bit(10));
    wr(A_STATUS, stat_bit(10));
    ticks(8'h10, 3);
    rd(A_STATUS, v); check("R7 periodic second", v, stat_bit(10));
    rd(a_cnt(10), v); check("R6 periodic clear", v, 0);
    wr(A_STATUS, 32'hFFFF_FFFF);

    // R9 channel 11 borrows channel 10's tick
    wr(a_ctrl(10), 32'h04);
    wr(a_match(10), 32'hFFFF_0000);
    wr(a_ctrl(11), 32'h180);
    wr(a_cnt(11), 0);
    ticks(8'h10, 4);
    rd(a_cnt(11), v); check("R9 borrowed tick", v, 4);
    wr(a_ctrl(11), 32'h181);
    ticks(8'h02, 3);
    rd(a_cnt(11), v); check("R9 own select ignored", v, 4);
    wr(a_ctrl(11), 32'h080);
    ticks(8'h10, 3);
    rd(a_cnt(11), v); check("R9 no borrow no count", v, 4);

    // R10 snapshot of channel 8 through channel 9 reads
    wr(a_ctrl(8), 1);
    wr(a_cnt(8), 0);
    wr(a_ctrl(9), 32'h280);
    ticks(8'h02, 7);
    rd(a_cnt(9), v); check("R10 odd counter read", v, 0);
    rd(A_SNAP, v);   check("R10 captured", v, 7);
    ticks(8'h02, 4);
    rd(A_SNAP, v);   check("R10 holds", v, 7);
    wr(a_ctrl(9), 32'h080);
    rd(a_cnt(9), v);
    rd(A_SNAP, v);   check("R10 no capture without bit", v, 7);
    wr(a_ctrl(9), 32'h280);
    rd(a_cnt(9), v);
    rd(A_SNAP, v);   check("R10 recapture", v, 11);

    // R12 bus write beats a tick in the same cycle
    wr(a_ctrl(4), 1);
    tick_in = 8'h02;
    wr(a_cnt(4), 100);
    tick_in = '0;
    rd(a_cnt(4), v); check("R12 write wins", v, 100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule